// File: doc/BRIEF.md
# Host Register Interface on a Shared Address/Data Bus

This block gives a host processor access to a line framer's bank of byte-wide control and status registers. The host uses one 8-bit bus for both address and data. A pulse on the address-latch strobe captures the register address from the bus. Separate active-low read and write strobes then move data while chip select is held low. The register contents are exposed as ports: control bytes go out to the framing logic, and event inputs come in from it. Two active-low interrupt lines each summarise one status register.

Two status registers record events. Each has a companion mask register. A status bit stays set after its event until the host reads that register, and the read clears it. Each interrupt line is low while any status bit that its mask allows is set. The bus model is synchronous to one clock. The read data is presented together with an output-enable flag, so the pad logic can tri-state the shared bus when the host is not reading.

Top module: `hbus_regfile`

## Requirements
- R1: A synchronous active-low reset sets every register and the latched address to zero. While reset is held and after it is released, `ad_oe` is 0 and both interrupt lines are 1.
- R2: On a clock edge with `ale` high, bits 5..0 of `ad_in` are captured as the register address, whatever the state of `cs_n`. Bits 7..6 are discarded, so address 0x45 selects register 5.
- R3: On a clock edge with `cs_n`=0, `wr_n`=0 and `ale`=0, `ad_in` is written to the register at the latched address if that address is in 2..59. Control register n (addresses 4..59) appears on `ctrl_o[8*(n-4)+7 : 8*(n-4)]`.
- R4: No register changes on a clock edge where `cs_n` is 1, `wr_n` is 1, or `ale` is 1.
- R5: `ad_oe` is 1 exactly while `cs_n`=0 and `rd_n`=0. In that state, `ad_out` holds the register at the latched address. At all other times `ad_out` is 0x00.
- R6: Latched addresses 60..63 read as 0x00, and writes to them change nothing.
- R7: Address 0 is status register A and address 1 is status register B. A bit in either becomes 1 on the edge after its bit in `stat1_set` or `stat2_set` is 1, and it stays 1. Host writes to addresses 0 and 1 are ignored.
- R8: When a read of a status register ends, the bits that were set at the last clock edge of the read are cleared. A read ends on the first edge where the read condition no longer holds. A bit that becomes set at that last edge or later is kept.
- R9: Address 2 masks status A and address 3 masks status B. `irq1_n` is 0 exactly while (status A AND mask A) is non-zero. `irq2_n` follows the same rule for status B and mask B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address latch strobe, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ad_in | input | 8 | Bus value as seen by the block (address or write data) |
| ad_out | output | 8 | Read data driven toward the bus |
| ad_oe | output | 1 | Output enable for the bus drivers |
| stat1_set | input | 8 | Event bits setting status register A |
| stat2_set | input | 8 | Event bits setting status register B |
| ctrl_o | output | 448 | Control registers 4..59, one byte each |
| irq1_n | output | 1 | Interrupt for status A, active low |
| irq2_n | output | 1 | Interrupt for status B, active low |

## Verification
The bench builds the block with its default values: 8-bit data, a 6-bit decoded address and 60 registers. With these values, the four unmapped addresses 60..63 and the aliasing of bus bits 7..6 can be reached directly from the bus. The default 60-register map also places the status, mask and control regions so that reads across each boundary are covered. An event pulse is driven in the same cycle as a status read, which tests the rule that the read clears only what it returned.

// File: rtl/hbus_pkg.sv
// Shared register-map constants for the host bus register interface.
// Assumes the status and mask registers occupy the lowest four addresses.
package hbus_pkg;
    localparam int STAT1_ADDR = 0;   // status register A
    localparam int STAT2_ADDR = 1;   // status register B
    localparam int MASK1_ADDR = 2;   // mask for status A
    localparam int MASK2_ADDR = 3;   // mask for status B
    localparam int RW_BASE    = 2;   // first host-writable address
    localparam int CTRL_BASE  = 4;   // first address exported on ctrl_o
endpackage

// File: rtl/hbus_addr_latch.sv
// Captures the register address from the shared bus while the latch strobe
// is high. Assumes the caller passes only the decoded low address bits.
module hbus_addr_latch #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [ADDR_W-1:0] ad_lo,
    output logic [ADDR_W-1:0] addr_q
);
    // Hold the address between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)   addr_q <= '0;
        else if (ale) addr_q <= ad_lo;
    end
endmodule

// File: rtl/hbus_stat_reg.sv
// One sticky status register. Event bits set it. At the end of a host read,
// it clears the bits that were present at the last read edge. Assumes rd_hit
// is high on each clock edge of a read aimed at this register.
module hbus_stat_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_i,
    input  logic              rd_hit,
    output logic [DATA_W-1:0] stat_q
);
    logic [DATA_W-1:0] pend_q;   // bits returned by the ongoing read
    logic              hit_q;    // read was active at the previous edge

    // Track the read and the snapshot of bits it returned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            pend_q <= '0;
        end else begin
            hit_q <= rd_hit;
            if (rd_hit) pend_q <= stat_q;
        end
    end

    // Accumulate events, and drop the read snapshot when the read ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                 stat_q <= '0;
        else if (hit_q && !rd_hit)  stat_q <= (stat_q & ~pend_q) | set_i;
        else                        stat_q <= stat_q | set_i;
    end
endmodule

// File: rtl/hbus_rw_bank.sv
// A contiguous bank of host-writable byte registers, flattened onto one
// vector. Assumes the bank starts at address BASE and holds COUNT registers.
module hbus_rw_bank #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    parameter int BASE   = 2,
    parameter int COUNT  = 58
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [COUNT*DATA_W-1:0] regs_o
);
    for (genvar g = 0; g < COUNT; g++) begin : g_reg
        logic [DATA_W-1:0] r_q;
        // Store write data when this register is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                r_q <= '0;
            else if (we_i && (addr_i == ADDR_W'(BASE + g)))
                r_q <= wdata_i;
        end
        assign regs_o[g*DATA_W +: DATA_W] = r_q;
    end
endmodule

// File: rtl/hbus_regfile.sv
// Host register interface: address latch, read/write decode, two sticky
// status registers with masks, control registers, and the interrupt outputs.
// Assumes a bus model synchronous to clk and 4 <= NUM_REGS <= 2**ADDR_W.
module hbus_regfile
    import hbus_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 6,
    parameter int NUM_REGS = 60
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cs_n,
    input  logic                                ale,
    input  logic                                rd_n,
    input  logic                                wr_n,
    input  logic [DATA_W-1:0]                   ad_in,
    output logic [DATA_W-1:0]                   ad_out,
    output logic                                ad_oe,
    input  logic [DATA_W-1:0]                   stat1_set,
    input  logic [DATA_W-1:0]                   stat2_set,
    output logic [(NUM_REGS-CTRL_BASE)*DATA_W-1:0] ctrl_o,
    output logic                                irq1_n,
    output logic                                irq2_n
);
    localparam int RW_COUNT = NUM_REGS - RW_BASE;
    localparam int CTRL_LO  = (CTRL_BASE - RW_BASE) * DATA_W;

    logic [ADDR_W-1:0]          addr_q;
    logic                       rd_act;
    logic                       wr_en;
    logic [RW_COUNT*DATA_W-1:0] rw_flat;
    logic [DATA_W-1:0]          stat1_v, stat2_v, mask1_v, mask2_v;
    logic [DATA_W-1:0]          rd_val;

    assign rd_act = !cs_n && !rd_n;
    assign wr_en  = !cs_n && !wr_n && !ale;

    hbus_addr_latch #(.ADDR_W(ADDR_W)) u_alat (
        .clk(clk), .rst_n(rst_n), .ale(ale),
        .ad_lo(ad_in[ADDR_W-1:0]), .addr_q(addr_q)
    );

    hbus_stat_reg #(.DATA_W(DATA_W)) u_stat1 (
        .clk(clk), .rst_n(rst_n), .set_i(stat1_set),
        .rd_hit(rd_act && (addr_q == ADDR_W'(STAT1_ADDR))), .stat_q(stat1_v)
    );

    hbus_stat_reg #(.DATA_W(DATA_W)) u_stat2 (
        .clk(clk), .rst_n(rst_n), .set_i(stat2_set),
        .rd_hit(rd_act && (addr_q == ADDR_W'(STAT2_ADDR))), .stat_q(stat2_v)
    );

    hbus_rw_bank #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(RW_BASE), .COUNT(RW_COUNT)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .we_i(wr_en), .addr_i(addr_q),
        .wdata_i(ad_in), .regs_o(rw_flat)
    );

    assign mask1_v = rw_flat[(MASK1_ADDR-RW_BASE)*DATA_W +: DATA_W];
    assign mask2_v = rw_flat[(MASK2_ADDR-RW_BASE)*DATA_W +: DATA_W];
    assign ctrl_o  = rw_flat[RW_COUNT*DATA_W-1:CTRL_LO];

    // Select the addressed register; unmapped addresses give zero.
    always_comb begin
        rd_val = '0;
        if (addr_q == ADDR_W'(STAT1_ADDR)) rd_val = stat1_v;
        if (addr_q == ADDR_W'(STAT2_ADDR)) rd_val = stat2_v;
        for (int k = 0; k < RW_COUNT; k++) begin
            if (addr_q == ADDR_W'(RW_BASE + k)) rd_val = rw_flat[k*DATA_W +: DATA_W];
        end
    end

    assign ad_oe  = rd_act;
    assign ad_out = rd_act ? rd_val : '0;
    assign irq1_n = ~|(stat1_v & mask1_v);
    assign irq2_n = ~|(stat2_v & mask2_v);
endmodule

// File: rtl/hbus_regfile_chk.sv
// Property checker for the host register interface, bound to the top module.
// Assumes it observes the latched address and the status and mask values.
module hbus_regfile_chk #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 6,
    parameter int NUM_REGS = 60,
    parameter int CTRL_W   = (NUM_REGS - 4) * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ale,
    input logic              wr_n,
    input logic [DATA_W-1:0] ad_out,
    input logic              ad_oe,
    input logic [DATA_W-1:0] stat1_set,
    input logic [DATA_W-1:0] stat2_set,
    input logic [CTRL_W-1:0] ctrl_o,
    input logic              irq1_n,
    input logic              irq2_n,
    input logic [ADDR_W-1:0] addr_q,
    input logic [DATA_W-1:0] stat1_v,
    input logic [DATA_W-1:0] stat2_v,
    input logic [DATA_W-1:0] mask1_v,
    input logic [DATA_W-1:0] mask2_v
);
    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ad_oe |-> (ad_out == '0));                                   // R5
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && (int'(addr_q) >= NUM_REGS)) |-> (ad_out == '0));    // R6
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || wr_n || ale) |=> $stable(ctrl_o));                   // R4
    AST_STAT_A_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat1_set) |=> ((stat1_v & $past(stat1_set)) == $past(stat1_set))); // R7
    AST_STAT_B_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat2_set) |=> ((stat2_v & $past(stat2_set)) == $past(stat2_set))); // R7
    AST_IRQ_A_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat1_v & mask1_v) == '0) |-> irq1_n);                      // R9
    AST_IRQ_B_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat2_v & mask2_v) == '0) |-> irq2_n);                      // R9
endmodule

bind hbus_regfile hbus_regfile_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ale(ale), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .stat1_set(stat1_set),
    .stat2_set(stat2_set), .ctrl_o(ctrl_o), .irq1_n(irq1_n),
    .irq2_n(irq2_n), .addr_q(addr_q), .stat1_v(stat1_v),
    .stat2_v(stat2_v), .mask1_v(mask1_v), .mask2_v(mask2_v)
);

// File: tb/hbus_regfile_test.sv
// Scoreboard bench: bus tasks queue expected read data, a monitor compares.
module hbus_regfile_test;
    localparam int CW = 56 * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] ad_in = '0, stat1_set = '0, stat2_set = '0;
    logic [7:0] ad_out;
    logic ad_oe, irq1_n, irq2_n;
    logic [CW-1:0] ctrl_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] mdl [0:63];
    logic [7:0] sa = '0, sb = '0;

    typedef struct { logic [7:0] exp; string tag; } exp_t;
    exp_t sb_q[$];
    exp_t item;
    event mon_ev;

    always #5 clk = ~clk;

    hbus_regfile uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .stat1_set(stat1_set), .stat2_set(stat2_set), .ctrl_o(ctrl_o),
        .irq1_n(irq1_n), .irq2_n(irq2_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Monitor: compare each queued expectation with the bus output.
    initial forever begin
        @(mon_ev);
        while (sb_q.size() > 0) begin
            item = sb_q.pop_front();
            chk(ad_oe === 1'b1, {item.tag, " oe"}, {31'd0, ad_oe}, 1);
            chk(ad_out === item.exp, item.tag, {24'd0, ad_out}, {24'd0, item.exp});
        end
    end

    task automatic latch(input logic [7:0] a);
        @(negedge clk); ale = 1'b1; ad_in = a;
        @(negedge clk); ale = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        latch(a);
        cs_n = 1'b0; wr_n = 1'b0; ad_in = d;
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
        if (a[5:0] >= 2 && a[5:0] <= 59) mdl[a[5:0]] = d;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [7:0] expv,
                            input string tag);
        latch(a);
        cs_n = 1'b0; rd_n = 1'b0;
        #1;
        sb_q.push_back('{expv, tag});
        -> mon_ev;
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic pulse(input bit which, input logic [7:0] v);
        @(negedge clk);
        if (which) stat2_set = v; else stat1_set = v;
        @(negedge clk); stat1_set = '0; stat2_set = '0;
        if (which) sb = sb | v; else sa = sa | v;
    endtask

    function automatic logic [7:0] cbyte(input int a);
        return ctrl_o[(a-4)*8 +: 8];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        chk(ad_oe == 1'b0 && irq1_n && irq2_n, "R1 outputs in reset",
            {29'd0, ad_oe, irq1_n, irq2_n}, 3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctrl_o == '0, "R1 ctrl cleared", {31'd0, |ctrl_o}, 0);
        bus_read(8'd4, 8'h00, "R1 reg4 after reset");
        bus_read(8'd0, 8'h00, "R1 status A after reset");

        // R3 writes across the writable range.
        bus_write(8'd4, 8'hA5);
        bus_write(8'd30, 8'h3C);
        bus_write(8'd59, 8'h81);
        bus_write(8'd2, 8'h00);
        bus_write(8'd3, 8'h00);
        chk(cbyte(4) == 8'hA5, "R3 ctrl byte 4", {24'd0, cbyte(4)}, 32'hA5);
        chk(cbyte(59) == 8'h81, "R3 ctrl byte 59", {24'd0, cbyte(59)}, 32'h81);
        bus_read(8'd30, 8'h3C, "R3 readback 30");
        bus_read(8'd59, 8'h81, "R3 readback 59");

        // R2 upper bus bits ignored in the address.
        bus_write(8'h45, 8'h5E);
        chk(cbyte(5) == 8'h5E, "R2 alias write to 5", {24'd0, cbyte(5)}, 32'h5E);
        bus_read(8'hC5, 8'h5E, "R2 alias read of 5");

        // R6 unmapped addresses.
        bus_write(8'd61, 8'hFF);
        bus_read(8'd61, 8'h00, "R6 read 61");
        bus_read(8'd60, 8'h00, "R6 read 60");
        chk(cbyte(59) == 8'h81 && cbyte(4) == 8'hA5, "R6 no side effect",
            {24'd0, cbyte(59)}, 32'h81);

        // R4 write without chip select.
        latch(8'd30);
        wr_n = 1'b0; ad_in = 8'h77;
        @(negedge clk); wr_n = 1'b1;
        bus_read(8'd30, 8'h3C, "R4 no write without cs");
        // R4 write strobe during the address phase.
        @(negedge clk); ale = 1'b1; cs_n = 1'b0; wr_n = 1'b0; ad_in = 8'd30;
        @(negedge clk); ale = 1'b0; cs_n = 1'b1; wr_n = 1'b1;
        chk(cbyte(30) == 8'h3C, "R4 no write with ale", {24'd0, cbyte(30)}, 32'h3C);

        // R5 enable needs both cs and rd.
        latch(8'd4);
        rd_n = 1'b0; #1;
        chk(ad_oe == 1'b0 && ad_out == 8'h00, "R5 rd without cs",
            {23'd0, ad_oe, ad_out}, 0);
        @(negedge clk); rd_n = 1'b1; cs_n = 1'b0; #1;
        chk(ad_oe == 1'b0 && ad_out == 8'h00, "R5 cs without rd",
            {23'd0, ad_oe, ad_out}, 0);
        @(negedge clk); cs_n = 1'b1;

        // R7 sticky status, writes ignored; R8 clear on read.
        pulse(1'b0, 8'h05);
        chk(irq1_n == 1'b1, "R9 masked status no irq", {31'd0, irq1_n}, 1);
        bus_write(8'd0, 8'hFF);
        bus_read(8'd0, sa, "R7 status A sticky");
        sa = '0;
        bus_read(8'd0, 8'h00, "R8 status A cleared by read");

        // R9 unmasked bit raises irq1_n, read clears it.
        bus_write(8'd2, 8'h04);
        bus_read(8'd2, 8'h04, "R9 mask A readback");
        pulse(1'b0, 8'h04);
        chk(irq1_n == 1'b0 && irq2_n == 1'b1, "R9 irq1 low",
            {30'd0, irq1_n, irq2_n}, 1);
        bus_read(8'd0, sa, "R7 status A value");
        sa = '0;
        @(negedge clk);
        chk(irq1_n == 1'b1, "R9 irq1 released after read", {31'd0, irq1_n}, 1);

        // R8 event in the same cycle as the last read edge survives.
        bus_write(8'd3, 8'h80);
        pulse(1'b1, 8'h01);
        latch(8'd1);
        cs_n = 1'b0; rd_n = 1'b0; stat2_set = 8'h80;
        #1;
        sb_q.push_back('{sb, "R8 status B during read"});
        -> mon_ev;
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1; stat2_set = '0;
        sb = 8'h80;
        @(negedge clk);
        chk(irq2_n == 1'b0, "R8 late event keeps irq2", {31'd0, irq2_n}, 0);
        bus_read(8'd1, sb, "R8 late event kept");
        sb = '0;
        bus_read(8'd1, 8'h00, "R8 status B empty");

        // R1 reset in mid-run.
        pulse(1'b1, 8'h80);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(irq2_n == 1'b1 && ctrl_o == '0, "R1 mid-run reset",
            {30'd0, irq2_n, |ctrl_o}, 2);
        bus_read(8'd30, 8'h00, "R1 reg cleared by reset");

        repeat (2) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule